// File: doc/BRIEF.md
# Power Mode Controller with Protection

This block tracks the power mode of a chip and moves it between run, wait and stop modes. Software programs it through four byte-wide registers. The first holds permission flags that can be written once after reset. The second holds the run and stop selections together with a sticky flag that records an aborted stop. The third holds the stop options, and the fourth is a read-only one-hot view of the current mode.

A move into a low-power or high-speed run mode happens only when software first grants permission and then selects the mode. A selection that is reserved or not permitted is dropped, and the field keeps its old value.

Stop entry begins with a sleep request qualified by a deep-sleep flag. A pending interrupt may cancel it during a short entry window. While the mode is stopped, the block gates the system and bus clock enables. A wake pulse returns the mode to the run mode that was active before entry.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, the four registers read as follows:
  - offset 0 (permissions) reads 0x00;
  - offset 1 (control) reads 0x00;
  - offset 2 (stop options) reads 0x03;
  - offset 3 (status) reads 0x01.

  Both clock enables are high and stop_entered is low.
- R2: The permission register takes only the first write after reset. It keeps bits 1 (very-low-leakage stop), 3 (low-leakage stop), 5 (very-low-power modes) and 7 (high-speed run), and the other bits read 0. Every later write is ignored.
- R3: The stop field, control bits [2:0], takes the following codes:
  - 000 (normal stop), always allowed;
  - 010 (very-low-power stop), needs permission bit 5;
  - 011 (low-leakage stop), needs permission bit 3;
  - 100 (very-low-leakage stop), needs permission bit 1.

  A write with any other code, or without the needed permission, leaves the field unchanged.
- R4: The run field, control bits [6:5], takes 00 (normal run), 10 (very-low-power run) and 11 (high-speed run). Code 10 needs permission bit 5 and code 11 needs permission bit 7. Either may be written only while the status shows normal run and the field holds 00. Code 01 is always rejected.
- R5: A write of 00 to the run field is rejected until the status shows the mode that the field selects.
- R6: The status register is always one-hot. Its bits are:
  - bit 0: normal run;
  - bit 1: normal stop;
  - bit 2: very-low-power run;
  - bit 3: very-low-power wait;
  - bit 4: very-low-power stop;
  - bit 5: low-leakage stop;
  - bit 6: very-low-leakage stop;
  - bit 7: high-speed run.

  It follows an accepted run-field change one clock after the write.
- R7: A sleep request with deep-sleep set, seen in normal or very-low-power run, starts stop entry and clears the aborted flag (control bit 3) in the same clock. Stop_entered rises two clocks later.
- R8: If an interrupt is pending in either clock of the entry window, the entry is abandoned. The aborted flag sets and the mode stays in run.
- R9: A stop request in high-speed run is ignored.
- R10: The partial-stop option, stop-option bits [7:6], acts when the stop field is 000. With 01, stop gates both clocks and the status stays in run. With 10, stop gates only the system clock and the status stays in run. With 00, the status shows normal stop and both clocks are gated. Every full stop mode gates both clocks.
- R11: With the debug flag set at entry, a normal or very-low-power stop still raises stop_entered, but the status does not change.
- R12: A wake pulse in any stop or wait mode returns the status to the run mode held before entry, turns both clocks back on and clears stop_entered.
- R13: A sleep request without deep-sleep in very-low-power run enters very-low-power wait. The wait gates the system clock only.
- R14: In the stop-option register, bits [2:0] (codes 0 to 3 only), bit 5 and bits [7:6] (codes 0 to 2 only) are writable. A reserved code leaves its field unchanged, bits 4:3 read 0, and writes to the status offset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| sleep_req | input | 1 | Sleep request |
| deep_sleep | input | 1 | Qualifies a sleep request as a stop request |
| irq_pending | input | 1 | Interrupt pending; aborts stop entry |
| wake | input | 1 | Wake pulse out of stop or wait |
| debug_en | input | 1 | Debug active |
| mode_onehot | output | 8 | Current mode, one-hot |
| sys_clk_en | output | 1 | System clock enable |
| bus_clk_en | output | 1 | Bus clock enable |
| stop_entered | output | 1 | High while a stop mode is held |

## Verification
The bench targets the following corner cases:
- **Return to normal run in the clock right after a run-mode write.** A design that ignored R5 would fall back to normal run before very-low-power run had taken effect.
- **An interrupt in the last clock of the entry window.** A design with the window one clock short would stop instead of setting the aborted flag.
- **Partial stop, the debug flag and high-speed run.** A careless design would report normal stop during these cases, or gate the bus clock in partial stop option 10.
- **Reserved codes in the control and stop-option fields.** A write with a reserved code must leave each field untouched, and a design that stored those codes would read back changed values.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int         ENTRY_CYCLES = 2,
  parameter logic [7:0] OPT_RESET    = 8'h03
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sleep_req,
  input  logic       deep_sleep,
  input  logic       irq_pending,
  input  logic       wake,
  input  logic       debug_en,
  output logic [7:0] mode_onehot,
  output logic       sys_clk_en,
  output logic       bus_clk_en,
  output logic       stop_entered
);
  localparam int PW = $clog2(ENTRY_CYCLES + 1);
  localparam logic [PW-1:0] LAST = PW'(ENTRY_CYCLES);
  localparam logic [7:0] M_RUN   = 8'h01;
  localparam logic [7:0] M_STOP  = 8'h02;
  localparam logic [7:0] M_VLPR  = 8'h04;
  localparam logic [7:0] M_VLPW  = 8'h08;
  localparam logic [7:0] M_VLPS  = 8'h10;
  localparam logic [7:0] M_LLS   = 8'h20;
  localparam logic [7:0] M_VLLS  = 8'h40;
  localparam logic [7:0] M_HSRUN = 8'h80;
  localparam logic [7:0] PERM_MASK = 8'hAA;

  logic [7:0]    perm_q;
  logic          perm_locked;
  logic [2:0]    stopm_q;
  logic [1:0]    runm_q;
  logic          abort_q;
  logic [2:0]    opt_sub_q;
  logic          opt_por_q;
  logic [1:0]    opt_part_q;
  logic [7:0]    stat_q;
  logic [7:0]    resume_q;
  logic [PW-1:0] phase_q;
  logic          stopped_q;
  logic          waiting_q;
  logic [1:0]    part_q;

  logic       wr_perm, wr_ctrl, wr_opt;
  logic       stop_ok, run_ok, idle, stop_go, wait_go;
  logic [1:0] run_new;
  logic [7:0] stop_target;

  assign wr_perm = reg_wr && reg_addr == 2'd0 && !perm_locked;
  assign wr_ctrl = reg_wr && reg_addr == 2'd1;
  assign wr_opt  = reg_wr && reg_addr == 2'd2;
  assign run_new = reg_wdata[6:5];

  always_comb begin
    case (reg_wdata[2:0])
      3'b000:  stop_ok = 1'b1;
      3'b010:  stop_ok = perm_q[5];
      3'b011:  stop_ok = perm_q[3];
      3'b100:  stop_ok = perm_q[1];
      default: stop_ok = 1'b0;
    endcase
  end

  always_comb begin
    run_ok = 1'b0;
    if (run_new != runm_q) begin
      case (run_new)
        2'b00: run_ok = (runm_q == 2'b10 && stat_q == M_VLPR) ||
                        (runm_q == 2'b11 && stat_q == M_HSRUN);
        2'b10: run_ok = perm_q[5] && stat_q == M_RUN && runm_q == 2'b00;
        2'b11: run_ok = perm_q[7] && stat_q == M_RUN && runm_q == 2'b00;
        default: run_ok = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perm_q      <= 8'h00;
      perm_locked <= 1'b0;
      stopm_q     <= 3'b000;
      runm_q      <= 2'b00;
      opt_sub_q   <= OPT_RESET[2:0];
      opt_por_q   <= OPT_RESET[5];
      opt_part_q  <= OPT_RESET[7:6];
    end else begin
      if (wr_perm) begin
        perm_q      <= reg_wdata & PERM_MASK;
        perm_locked <= 1'b1;
      end
      if (wr_ctrl && stop_ok) stopm_q <= reg_wdata[2:0];
      if (wr_ctrl && run_ok)  runm_q  <= run_new;
      if (wr_opt) begin
        opt_por_q <= reg_wdata[5];
        if (!reg_wdata[2])           opt_sub_q  <= reg_wdata[2:0];
        if (reg_wdata[7:6] != 2'b11) opt_part_q <= reg_wdata[7:6];
      end
    end
  end

  assign idle    = phase_q == '0 && !stopped_q && !waiting_q;
  assign stop_go = idle && sleep_req && deep_sleep && (stat_q == M_RUN || stat_q == M_VLPR);
  assign wait_go = idle && sleep_req && !deep_sleep && stat_q == M_VLPR;

  always_comb begin
    case (stopm_q)
      3'b000:  stop_target = (opt_part_q != 2'b00 || debug_en) ? stat_q : M_STOP;
      3'b010:  stop_target = debug_en ? stat_q : M_VLPS;
      3'b011:  stop_target = M_LLS;
      3'b100:  stop_target = M_VLLS;
      default: stop_target = stat_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q    <= M_RUN;
      resume_q  <= M_RUN;
      phase_q   <= '0;
      stopped_q <= 1'b0;
      waiting_q <= 1'b0;
      part_q    <= 2'b00;
      abort_q   <= 1'b0;
    end else if (phase_q != '0) begin
      if (irq_pending) begin
        abort_q <= 1'b1;
        phase_q <= '0;
      end else if (phase_q == LAST) begin
        phase_q   <= '0;
        stopped_q <= 1'b1;
        stat_q    <= stop_target;
        part_q    <= (stopm_q == 3'b000) ? opt_part_q : 2'b00;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end else if (stopped_q || waiting_q) begin
      if (wake) begin
        stat_q    <= resume_q;
        stopped_q <= 1'b0;
        waiting_q <= 1'b0;
      end
    end else if (stop_go) begin
      phase_q  <= PW'(1);
      abort_q  <= 1'b0;
      resume_q <= stat_q;
    end else if (wait_go) begin
      waiting_q <= 1'b1;
      resume_q  <= stat_q;
      stat_q    <= M_VLPW;
    end else begin
      if (stat_q == M_RUN && runm_q == 2'b10)        stat_q <= M_VLPR;
      else if (stat_q == M_RUN && runm_q == 2'b11)   stat_q <= M_HSRUN;
      else if (stat_q == M_VLPR && runm_q == 2'b00)  stat_q <= M_RUN;
      else if (stat_q == M_HSRUN && runm_q == 2'b00) stat_q <= M_RUN;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = perm_q;
      2'd1:    reg_rdata = {1'b0, runm_q, 1'b0, abort_q, stopm_q};
      2'd2:    reg_rdata = {opt_part_q, opt_por_q, 2'b00, opt_sub_q};
      default: reg_rdata = stat_q;
    endcase
  end

  assign mode_onehot  = stat_q;
  assign stop_entered = stopped_q;
  assign sys_clk_en   = !(stopped_q || waiting_q);
  assign bus_clk_en   = !stopped_q || part_q == 2'b10;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int ENTRY_CYCLES = 2,
  parameter int PW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    mode_onehot,
  input logic          sys_clk_en,
  input logic          bus_clk_en,
  input logic          stop_entered,
  input logic [7:0]    perm_q,
  input logic          perm_locked,
  input logic          abort_q,
  input logic [PW-1:0] phase_q
);
  p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_onehot) == 1);

  p_perm_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(perm_locked) |-> $stable(perm_q));

  p_clk_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_entered && !mode_onehot[3]) |-> (sys_clk_en && bus_clk_en));

  p_abort_keeps_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_q) |-> $stable(mode_onehot));

  p_hsrun_nostop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_onehot[7] |=> !stop_entered);

  p_entry_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_entered) |-> $past(phase_q) == PW'(ENTRY_CYCLES));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.ENTRY_CYCLES(ENTRY_CYCLES), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_onehot(mode_onehot), .sys_clk_en(sys_clk_en),
  .bus_clk_en(bus_clk_en), .stop_entered(stop_entered), .perm_q(perm_q),
  .perm_locked(perm_locked), .abort_q(abort_q), .phase_q(phase_q)
);

// File: tb/pwr_mode_ctrl_test.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic sleep_req = 1'b0, deep_sleep = 1'b0, irq_pending = 1'b0, wake = 1'b0, debug_en = 1'b0;
  logic [7:0] mode_onehot;
  logic sys_clk_en, bus_clk_en, stop_entered;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  pwr_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sleep_req(sleep_req), .deep_sleep(deep_sleep),
    .irq_pending(irq_pending), .wake(wake), .debug_en(debug_en), .mode_onehot(mode_onehot),
    .sys_clk_en(sys_clk_en), .bus_clk_en(bus_clk_en), .stop_entered(stop_entered)
  );

  // Behavioural reference model
  int m_perm, m_stop, m_run, m_sub, m_por, m_part, m_stat, m_resume, m_win, m_gate;
  bit m_locked, m_abort, m_stopped, m_wait;

  function automatic int model_read(int a);
    case (a)
      0: return m_perm;
      1: return (m_run << 5) | (int'(m_abort) << 3) | m_stop;
      2: return (m_part << 6) | (m_por << 5) | m_sub;
      default: return m_stat;
    endcase
  endfunction

  function automatic bit stop_allowed(int code, int p);
    if (code == 0) return 1;
    if (code == 2) return p[5];
    if (code == 3) return p[3];
    if (code == 4) return p[1];
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_perm = 0; m_locked = 0; m_stop = 0; m_run = 0; m_sub = 3; m_por = 0; m_part = 0;
      m_stat = 1; m_resume = 1; m_win = 0; m_gate = 0; m_abort = 0; m_stopped = 0; m_wait = 0;
    end else begin
      int o_stat, o_run, o_perm, o_stop, o_part, nr, target;
      o_stat = m_stat; o_run = m_run; o_perm = m_perm; o_stop = m_stop; o_part = m_part;
      if (reg_wr && reg_addr == 0 && !m_locked) begin m_perm = reg_wdata & 8'hAA; m_locked = 1; end
      if (reg_wr && reg_addr == 1) begin
        if (stop_allowed(reg_wdata[2:0], o_perm)) m_stop = reg_wdata[2:0];
        nr = reg_wdata[6:5];
        if (nr == 2 && o_perm[5] && o_stat == 1 && o_run == 0) m_run = 2;
        if (nr == 3 && o_perm[7] && o_stat == 1 && o_run == 0) m_run = 3;
        if (nr == 0 && ((o_run == 2 && o_stat == 4) || (o_run == 3 && o_stat == 128))) m_run = 0;
      end
      if (reg_wr && reg_addr == 2) begin
        m_por = reg_wdata[5];
        if (reg_wdata[2:0] < 4) m_sub = reg_wdata[2:0];
        if (reg_wdata[7:6] != 3) m_part = reg_wdata[7:6];
      end
      if (m_win > 0) begin
        if (irq_pending) begin m_abort = 1; m_win = 0; end
        else if (m_win == 2) begin
          target = o_stat;
          if (o_stop == 0 && o_part == 0 && !debug_en) target = 2;
          if (o_stop == 2 && !debug_en) target = 16;
          if (o_stop == 3) target = 32;
          if (o_stop == 4) target = 64;
          m_stat = target; m_win = 0; m_stopped = 1;
          m_gate = (o_stop == 0) ? o_part : 0;
        end else m_win = m_win + 1;
      end else if (m_stopped || m_wait) begin
        if (wake) begin m_stat = m_resume; m_stopped = 0; m_wait = 0; end
      end else if (sleep_req && deep_sleep && (o_stat == 1 || o_stat == 4)) begin
        m_win = 1; m_abort = 0; m_resume = o_stat;
      end else if (sleep_req && !deep_sleep && o_stat == 4) begin
        m_wait = 1; m_resume = 4; m_stat = 8;
      end else begin
        if (o_stat == 1 && o_run == 2) m_stat = 4;
        else if (o_stat == 1 && o_run == 3) m_stat = 128;
        else if ((o_stat == 4 || o_stat == 128) && o_run == 0) m_stat = 1;
      end
    end
  end

  task automatic check(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      check(tag, "mode", mode_onehot, m_stat);
      check(tag, "sys_clk_en", sys_clk_en, int'(!(m_stopped || m_wait)));
      check(tag, "bus_clk_en", bus_clk_en, int'(!m_stopped || m_gate == 2));
      check(tag, "stop_entered", stop_entered, int'(m_stopped));
      check(tag, "rdata", reg_rdata, model_read(reg_addr));
    end
  end

  task automatic wr(int a, int d);
    reg_wr = 1; reg_addr = 2'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(string r, int a, int exp);
    reg_addr = 2'(a);
    #2;
    check(r, "read", reg_rdata, exp);
  endtask

  task automatic outs(string r, int mode, int s, int b, int st);
    #2;
    check(r, "mode", mode_onehot, mode);
    check(r, "sys", sys_clk_en, s);
    check(r, "bus", bus_clk_en, b);
    check(r, "stop", stop_entered, st);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sleep(bit deep);
    sleep_req = 1; deep_sleep = deep;
    @(negedge clk);
    sleep_req = 0; deep_sleep = 0;
  endtask

  task automatic wake_up();
    wake = 1;
    @(negedge clk);
    wake = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    tag = "R1";
    rd("R1", 0, 8'h00); rd("R1", 1, 8'h00); rd("R1", 2, 8'h03); rd("R1", 3, 8'h01);
    outs("R1", 8'h01, 1, 1, 0);

    tag = "R3";
    wr(1, 8'h02); rd("R3", 1, 8'h00);
    tag = "R4";
    wr(1, 8'h40); rd("R4", 1, 8'h00);

    tag = "R14";
    wr(2, 8'hFF); rd("R14", 2, 8'h23);
    wr(2, 8'h80); rd("R14", 2, 8'h80);
    wr(2, 8'h00); rd("R14", 2, 8'h00);
    wr(3, 8'h55); rd("R14", 3, 8'h01);

    tag = "R2";
    wr(0, 8'hFF); rd("R2", 0, 8'hAA);
    wr(0, 8'h00); rd("R2", 0, 8'hAA);

    tag = "R3";
    wr(1, 8'h05); rd("R3", 1, 8'h00);
    wr(1, 8'h03); rd("R3", 1, 8'h03);

    tag = "R4";
    wr(1, 8'h23); rd("R4", 1, 8'h03);
    wr(1, 8'h43);
    outs("R6", 8'h01, 1, 1, 0);
    tag = "R5";
    wr(1, 8'h03); rd("R5", 1, 8'h43);
    outs("R6", 8'h04, 1, 1, 0);
    wr(1, 8'h03); rd("R5", 1, 8'h03);
    cyc(1); outs("R5", 8'h01, 1, 1, 0);

    tag = "R13";
    wr(1, 8'h43); cyc(1);
    sleep(0); outs("R13", 8'h08, 0, 1, 0);
    wake_up(); outs("R13", 8'h04, 1, 1, 0);

    tag = "R12";
    sleep(1); cyc(2); outs("R12", 8'h20, 0, 0, 1);
    wake_up(); outs("R12", 8'h04, 1, 1, 0);
    wr(1, 8'h03); cyc(1); outs("R12", 8'h01, 1, 1, 0);

    tag = "R7";
    wr(1, 8'h00);
    sleep(1); cyc(1); outs("R7", 8'h01, 1, 1, 0);
    cyc(1); outs("R10", 8'h02, 0, 0, 1);
    wake_up(); outs("R12", 8'h01, 1, 1, 0);

    tag = "R8";
    sleep(1); cyc(1);
    irq_pending = 1; cyc(1); irq_pending = 0;
    rd("R8", 1, 8'h08); outs("R8", 8'h01, 1, 1, 0);
    cyc(2); outs("R8", 8'h01, 1, 1, 0);
    tag = "R7";
    sleep(1); rd("R7", 1, 8'h00);
    cyc(2); outs("R7", 8'h02, 0, 0, 1);
    wake_up();

    tag = "R10";
    wr(2, 8'h80);
    sleep(1); cyc(2); outs("R10", 8'h01, 0, 1, 1);
    wake_up();
    wr(2, 8'h40);
    sleep(1); cyc(2); outs("R10", 8'h01, 0, 0, 1);
    wake_up();
    wr(2, 8'h00);

    tag = "R11";
    wr(1, 8'h02); debug_en = 1;
    sleep(1); cyc(2); outs("R11", 8'h01, 0, 0, 1);
    wake_up(); debug_en = 0;
    sleep(1); cyc(2); outs("R11", 8'h10, 0, 0, 1);
    wake_up(); outs("R12", 8'h01, 1, 1, 0);

    tag = "R9";
    wr(1, 8'h60); cyc(1); outs("R9", 8'h80, 1, 1, 0);
    sleep(1); cyc(3); outs("R9", 8'h80, 1, 1, 0);
    wr(1, 8'h00); cyc(1); outs("R9", 8'h01, 1, 1, 0);

    tag = "R6";
    cyc(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule